// File: doc/BRIEF.md
# Pop-All Register Restore Sequencer

This block carries out the "restore every general-purpose register from the stack" operation of a 32-bit core. A one-cycle start pulse launches it. The block then reads eight consecutive stack slots through a request/valid memory read port. It writes seven of the results into an eight-entry register file, and it advances the stack pointer past each slot as it goes. The slot that holds the saved stack pointer is read and then discarded.

Before any memory access, the block checks the start request for faults: an illegal mode or a lock prefix, a stack range that falls outside the segment limit, and a misaligned stack at user privilege with alignment checking on. A faulting request ends with a one-cycle fault code. In that case no read is issued, and neither the register file nor the stack pointer is written. The operand size selects 4-byte or 2-byte slots. In 2-byte mode only the low halves of the destination registers are written.

Top module: `popall_seq`

## Requirements
- R1: After reset the block is idle: busy_o, mem_req_o, rf_we_o, sp_we_o and done_o are low, and fault_code_o is 0.
- R2: A fault-free start produces exactly seven register writes, in this order of rf_waddr_o: 7, 6, 5, 3, 2, 1, 0. Each write carries the data of the read at slot k, where waddr = 7 - k.
- R3: Slot 3 is read, but its data is never written. Register index 4, the stack-pointer entry, receives no write.
- R4: The eight reads go to addresses sp_i + k*S for k = 0..7. S is 4 when opsz32_i=1 and 2 when opsz32_i=0.
- R5: With opsz32_i=1, rf_wstrb_o is 2'b11 and rf_wdata_o equals the read data. With opsz32_i=0, rf_wstrb_o is 2'b01 (low half only) and rf_wdata_o is {16'h0, read[15:0]}.
- R6: Every accepted read beat pulses sp_we_o with sp_wdata_o = beat address + S. This gives eight pulses, and the last value is sp_i + 8*S.
- R7: mode64_i=1 at start gives fault_code_o=1 (invalid opcode) for one cycle, with no read, no register write and no stack-pointer write.
- R8: lock_i=1 at start gives fault_code_o=1 with no access.
- R9: A stack fault is reported as fault_code_o=2, with no access. It is raised when sp_i > ss_limit_i, or when sp_i + 8*S - 1 > ss_limit_i. That sum is computed without wrap, so a range that crosses the top of the address space faults. A range that ends exactly at the limit is accepted.
- R10: An alignment fault is reported as fault_code_o=3, with no access. It is raised when align_en_i=1, cpl_i=3 and sp_i is not a multiple of S. The same misalignment at any other privilege level runs normally.
- R11: Fault priority is invalid opcode, then stack, then alignment.
- R12: While mem_req_o is high and mem_valid_i is low, mem_req_o stays high and mem_addr_o is held on the next cycle.
- R13: done_o pulses for one cycle, one cycle after the last read beat. A start_i that arrives while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode64_i | input | 1 | Core is in 64-bit mode |
| lock_i | input | 1 | Lock prefix present |
| opsz32_i | input | 1 | 1 = 4-byte slots, 0 = 2-byte slots |
| align_en_i | input | 1 | Alignment checking enabled |
| cpl_i | input | 2 | Current privilege level |
| sp_i | input | 32 | Stack pointer at start |
| ss_limit_i | input | 32 | Highest valid stack offset |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read address |
| mem_valid_i | input | 1 | Read data valid, ends the current beat |
| mem_rdata_i | input | 32 | Read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register index (0..7) |
| rf_wdata_o | output | 32 | Register write data |
| rf_wstrb_o | output | 2 | Half-word write strobes, bit 0 = low half |
| sp_we_o | output | 1 | Stack pointer update |
| sp_wdata_o | output | 32 | New stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_code_o | output | 2 | One-cycle fault report: 0 none, 1 invalid opcode, 2 stack, 3 alignment |

## Verification
The restore path is run with both slot sizes and with memory stalls of zero, two and three cycles. A mismatch in write order, in the half strobe or in address hold shows up only under one of these combinations. A second start fired mid-run shows whether requests are properly ignored while busy. Stack ranges that end exactly at the limit, one byte past it, past the limit at the start, and across the top of the address space separate the start check, the end check and wrap handling from one another. Fault inputs are combined in pairs to pin down the priority order, and a misaligned stack at privilege 0 shows that the alignment check depends on privilege.

// File: rtl/popall_pkg.sv
package popall_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_SS   = 2'd2,
    FLT_AC   = 2'd3
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/popall_fault_chk.sv
module popall_fault_chk
  import popall_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic            mode64_i,
  input  logic            lock_i,
  input  logic            sz32_i,
  input  logic            align_en_i,
  input  logic [1:0]      cpl_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] limit_i,
  output fault_e          code_o
);
  localparam int unsigned FULL_B = XLEN / 8;
  localparam int unsigned HALF_B = XLEN / 16;

  logic [XLEN:0] span;
  logic [XLEN:0] end_addr;
  logic          ss_flt;
  logic          misal;
  logic          ac_flt;

  always_comb begin
    span     = sz32_i ? (XLEN+1)'(NUM_SLOTS * FULL_B) : (XLEN+1)'(NUM_SLOTS * HALF_B);
    // computed one bit wider so that a range crossing the top is seen
    end_addr = {1'b0, sp_i} + span - (XLEN+1)'(1);
    ss_flt   = ({1'b0, sp_i} > {1'b0, limit_i}) || (end_addr > {1'b0, limit_i});
    misal    = sz32_i ? (sp_i[1:0] != 2'b00) : sp_i[0];
    ac_flt   = align_en_i && (cpl_i == 2'd3) && misal;
  end

  always_comb begin
    if (mode64_i || lock_i) code_o = FLT_UD;
    else if (ss_flt)        code_o = FLT_SS;
    else if (ac_flt)        code_o = FLT_AC;
    else                    code_o = FLT_NONE;
  end
endmodule

// File: rtl/popall_slot_ctr.sv
module popall_slot_ctr #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SW        = $clog2(NUM_SLOTS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic            sz32_i,
  input  logic [XLEN-1:0] base_i,
  output logic [SW-1:0]   slot_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] next_addr_o,
  output logic            last_o
);
  localparam int unsigned FULL_B = XLEN / 8;
  localparam int unsigned HALF_B = XLEN / 16;

  logic [XLEN-1:0] step_amt;

  assign step_amt    = sz32_i ? XLEN'(FULL_B) : XLEN'(HALF_B);
  assign next_addr_o = addr_o + step_amt;
  assign last_o      = (slot_o == SW'(NUM_SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      slot_o <= '0;
      addr_o <= base_i;
    end else if (step_i && !last_o) begin
      slot_o <= slot_o + SW'(1);
      addr_o <= next_addr_o;
    end
  end

  a_r4_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !last_o && !load_i) |=> (addr_o - $past(addr_o)) == $past(step_amt));
endmodule

// File: rtl/popall_wr_map.sv
module popall_wr_map #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SKIP_SLOT = 3,
  parameter int unsigned SW        = $clog2(NUM_SLOTS)
) (
  input  logic            beat_i,
  input  logic            sz32_i,
  input  logic [SW-1:0]   slot_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic            we_o,
  output logic [SW-1:0]   waddr_o,
  output logic [XLEN-1:0] wdata_o,
  output logic [1:0]      wstrb_o
);
  localparam int unsigned HW = XLEN / 2;

  assign we_o    = beat_i && (slot_i != SW'(SKIP_SLOT));
  assign waddr_o = SW'(NUM_SLOTS - 1) - slot_i;

  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign wstrb_o[h]              = 1'b1;
      assign wdata_o[h*HW +: HW]     = rdata_i[h*HW +: HW];
    end else begin : g_hi
      assign wstrb_o[h]              = sz32_i;
      assign wdata_o[h*HW +: HW]     = sz32_i ? rdata_i[h*HW +: HW] : '0;
    end
  end
endmodule

// File: rtl/popall_seq.sv
module popall_seq
  import popall_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SKIP_SLOT = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         mode64_i,
  input  logic                         lock_i,
  input  logic                         opsz32_i,
  input  logic                         align_en_i,
  input  logic [1:0]                   cpl_i,
  input  logic [XLEN-1:0]              sp_i,
  input  logic [XLEN-1:0]              ss_limit_i,
  output logic                         mem_req_o,
  output logic [XLEN-1:0]              mem_addr_o,
  input  logic                         mem_valid_i,
  input  logic [XLEN-1:0]              mem_rdata_i,
  output logic                         rf_we_o,
  output logic [$clog2(NUM_SLOTS)-1:0] rf_waddr_o,
  output logic [XLEN-1:0]              rf_wdata_o,
  output logic [1:0]                   rf_wstrb_o,
  output logic                         sp_we_o,
  output logic [XLEN-1:0]              sp_wdata_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [1:0]                   fault_code_o
);
  localparam int unsigned SW = $clog2(NUM_SLOTS);

  state_e          state_q;
  fault_e          chk_code;
  fault_e          code_q;
  logic            sz32_q;
  logic            done_q;
  logic            accept;
  logic            go;
  logic            beat;
  logic            last;
  logic [SW-1:0]   slot;
  logic [XLEN-1:0] addr;
  logic [XLEN-1:0] next_addr;

  popall_fault_chk #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .mode64_i  (mode64_i),
    .lock_i    (lock_i),
    .sz32_i    (opsz32_i),
    .align_en_i(align_en_i),
    .cpl_i     (cpl_i),
    .sp_i      (sp_i),
    .limit_i   (ss_limit_i),
    .code_o    (chk_code)
  );

  assign accept = (state_q == ST_IDLE) && start_i;
  assign go     = accept && (chk_code == FLT_NONE);
  assign beat   = (state_q == ST_RUN) && mem_valid_i;

  popall_slot_ctr #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (go),
    .step_i     (beat),
    .sz32_i     (sz32_q),
    .base_i     (sp_i),
    .slot_o     (slot),
    .addr_o     (addr),
    .next_addr_o(next_addr),
    .last_o     (last)
  );

  popall_wr_map #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS), .SKIP_SLOT(SKIP_SLOT), .SW(SW)) u_map (
    .beat_i (beat),
    .sz32_i (sz32_q),
    .slot_i (slot),
    .rdata_i(mem_rdata_i),
    .we_o   (rf_we_o),
    .waddr_o(rf_waddr_o),
    .wdata_o(rf_wdata_o),
    .wstrb_o(rf_wstrb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= FLT_NONE;
      sz32_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      code_q <= accept ? chk_code : FLT_NONE;
      done_q <= beat && last;
      if (go) begin
        state_q <= ST_RUN;
        sz32_q  <= opsz32_i;
      end else if (beat && last) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign mem_req_o    = (state_q == ST_RUN);
  assign mem_addr_o   = addr;
  assign sp_we_o      = beat;
  assign sp_wdata_o   = next_addr;
  assign busy_o       = (state_q == ST_RUN);
  assign done_o       = done_q;
  assign fault_code_o = code_q;

  a_r12_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r3_no_sp_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != SW'(NUM_SLOTS - 1 - SKIP_SLOT)));
  a_r5_half_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !sz32_q) |-> (rf_wstrb_o == 2'b01));
  a_r7_fault_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o != 2'd0) |-> (!mem_req_o && !sp_we_o && !rf_we_o));
  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r13_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(mem_valid_i && last)) |=> busy_o);
  a_r11_ud_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode64_i) |=> (fault_code_o == 2'd1 && !mem_req_o));
endmodule

// File: tb/popall_seq_bench.sv
module popall_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode64 = 1'b0, lock = 1'b0, sz32 = 1'b1, al_en = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic [31:0] sp = '0, limit = 32'hFFFF_FFFF;
  logic        req, vld;
  logic [31:0] addr, rdata;
  logic        we, spwe, busy, done;
  logic [2:0]  waddr;
  logic [31:0] wdata, spw;
  logic [1:0]  wstrb, fcode;

  always #5 clk = ~clk;

  popall_seq u_popall_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode64_i(mode64), .lock_i(lock),
    .opsz32_i(sz32), .align_en_i(al_en), .cpl_i(cpl), .sp_i(sp), .ss_limit_i(limit),
    .mem_req_o(req), .mem_addr_o(addr), .mem_valid_i(vld), .mem_rdata_i(rdata),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata), .rf_wstrb_o(wstrb),
    .sp_we_o(spwe), .sp_wdata_o(spw), .busy_o(busy), .done_o(done), .fault_code_o(fcode)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] data;
    logic [1:0]  strb;
  } wr_item_t;

  wr_item_t exp_q[$];
  int checks = 0, fails = 0;
  int cyc = 0, wr_cnt = 0, sp_cnt = 0, req_seen = 0;
  int last_sp_cyc = 0, done_cyc = 0;
  logic [31:0] last_sp = '0;
  int stall_len = 0, nbeat = 0, wcnt = 0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h0F1E};
  endfunction

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, expv);
    end
  endtask

  // memory responder with variable stall
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0; rdata <= '0; wcnt <= 0;
    end else if (vld) begin
      vld <= 1'b0;
    end else if (req) begin
      if (wcnt == 0) begin
        vld   <= 1'b1;
        rdata <= mdata(addr);
        wcnt  <= (stall_len == 0) ? 0 : (nbeat % (stall_len + 1));
        nbeat <= nbeat + 1;
      end else begin
        wcnt <= wcnt - 1;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (req) req_seen++;
      if (prev_hold) chk(req && addr == prev_addr, "R12 hold", addr, prev_addr);
      prev_hold = req && !vld;
      prev_addr = addr;
      if (spwe) begin sp_cnt++; last_sp = spw; last_sp_cyc = cyc; end
      if (done) done_cyc = cyc;
      if (we) begin
        wr_cnt++;
        chk(waddr != 3'd4, "R3 skip", {29'd0, waddr}, 32'd4);
        if (exp_q.size() == 0) chk(1'b0, "R2 extra write", {29'd0, waddr}, 32'hX);
        else begin
          wr_item_t e;
          e = exp_q.pop_front();
          chk(waddr == e.idx, "R2 order", {29'd0, waddr}, {29'd0, e.idx});
          chk(wdata == e.data, "R4/R5 data", wdata, e.data);
          chk(wstrb == e.strb, "R5 strobe", {30'd0, wstrb}, {30'd0, e.strb});
        end
      end
    end
  end

  task automatic clear_cnt();
    wr_cnt = 0; sp_cnt = 0; req_seen = 0;
  endtask

  task automatic setup(input logic [31:0] s, input bit w, input logic [31:0] lim,
                       input logic [1:0] pl, input bit ae, input bit m64, input bit lk);
    sp = s; sz32 = w; limit = lim; cpl = pl; al_en = ae; mode64 = m64; lock = lk;
  endtask

  task automatic run_ok(input logic [31:0] s, input bit w, input logic [31:0] lim,
                        input logic [1:0] pl, input bit ae, input int stall, input bit poke,
                        input string tag);
    int size;
    int guard;
    size = w ? 4 : 2;
    stall_len = stall;
    for (int k = 0; k < 8; k++) begin
      if (k != 3) begin
        wr_item_t it;
        logic [31:0] d;
        d = mdata(s + 32'(k * size));
        it.idx  = 3'(7 - k);
        it.data = w ? d : {16'h0, d[15:0]};
        it.strb = w ? 2'b11 : 2'b01;
        exp_q.push_back(it);
      end
    end
    @(negedge clk); #1;
    clear_cnt();
    setup(s, w, lim, pl, ae, 1'b0, 1'b0);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(fcode == 2'd0, {tag, " no fault"}, {30'd0, fcode}, 32'd0);
    if (poke) begin
      @(negedge clk); #1;
      sp = s + 32'h100; start = 1'b1;   // R13: must be ignored while busy
      @(negedge clk); #1;
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 500) begin @(negedge clk); #1; guard++; end
    chk(done == 1'b1, {tag, " R13 done seen"}, {31'd0, done}, 32'd1);
    chk(done_cyc - last_sp_cyc == 1, {tag, " R13 done timing"}, 32'(done_cyc - last_sp_cyc), 32'd1);
    chk(sp_cnt == 8, {tag, " R6 sp updates"}, 32'(sp_cnt), 32'd8);
    chk(last_sp == s + 32'(8 * size), {tag, " R6 final sp"}, last_sp, s + 32'(8 * size));
    chk(wr_cnt == 7, {tag, " R2 write count"}, 32'(wr_cnt), 32'd7);
    chk(exp_q.size() == 0, {tag, " R2 all writes seen"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    @(negedge clk); #1;
    chk(!done, {tag, " R13 done one cycle"}, {31'd0, done}, 32'd0);
    @(negedge clk); #1;
    chk(!busy && !req, {tag, " R13 idle after"}, {30'd0, busy, req}, 32'd0);
  endtask

  task automatic fault_op(input logic [31:0] s, input bit w, input logic [31:0] lim,
                          input logic [1:0] pl, input bit ae, input bit m64, input bit lk,
                          input logic [1:0] expc, input string tag);
    @(negedge clk); #1;
    clear_cnt();
    setup(s, w, lim, pl, ae, m64, lk);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(fcode == expc, {tag, " code"}, {30'd0, fcode}, {30'd0, expc});
    mode64 = 1'b0; lock = 1'b0;
    repeat (4) begin @(negedge clk); #1; end
    chk(req_seen == 0 && wr_cnt == 0 && sp_cnt == 0, {tag, " no access"},
        32'(req_seen + wr_cnt + sp_cnt), 32'd0);
    chk(fcode == 2'd0, {tag, " code pulse"}, {30'd0, fcode}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!busy && !req, "R1 busy/req", {30'd0, busy, req}, 32'd0);
    chk(!we && !spwe && !done, "R1 writes/done", {29'd0, we, spwe, done}, 32'd0);
    chk(fcode == 2'd0, "R1 fault", {30'd0, fcode}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !req, "R1 idle after release", {30'd0, busy, req}, 32'd0);

    run_ok(32'h0000_1000, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b0, 0, 1'b0, "R2 R4 32b");
    run_ok(32'h0000_2002, 1'b0, 32'hFFFF_FFFF, 2'd3, 1'b1, 2, 1'b0, "R5 16b stall");
    run_ok(32'h0000_0800, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b0, 3, 1'b1, "R12 R13 poke");
    run_ok(32'h0000_3000, 1'b1, 32'h0000_301F, 2'd0, 1'b0, 1, 1'b0, "R9 end at limit 32b");
    run_ok(32'h0000_3000, 1'b0, 32'h0000_300F, 2'd0, 1'b0, 0, 1'b0, "R9 end at limit 16b");
    run_ok(32'h0000_1002, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b1, 0, 1'b0, "R10 misaligned cpl0");

    fault_op(32'h0000_3000, 1'b1, 32'h0000_301E, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, "R9 end past limit 32b");
    fault_op(32'h0000_3000, 1'b0, 32'h0000_300E, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, "R9 end past limit 16b");
    fault_op(32'h0000_5000, 1'b1, 32'h0000_4FFF, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, "R9 start past limit");
    fault_op(32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, "R9 wrap");
    fault_op(32'h0000_1000, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, "R7 mode64");
    fault_op(32'h0000_1000, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, "R8 lock");
    fault_op(32'h0000_1002, 1'b1, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b0, 1'b0, 2'd3, "R10 ac 32b");
    fault_op(32'h0000_1001, 1'b0, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b0, 1'b0, 2'd3, "R10 ac 16b");
    fault_op(32'h0000_5000, 1'b1, 32'h0000_1000, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, "R11 ud over ss");
    fault_op(32'h0000_5002, 1'b1, 32'h0000_1000, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2, "R11 ss over ac");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule